// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog that counts system-clock cycles through a selectable prescaler (divide by 16 or by 128) into a down-counter of `CNT_W` bits. The default width is 15, so a full period is 32768 prescaled ticks. At 16 MHz with divide-by-16 that comes to roughly 32.8 ms. Software keeps the watchdog alive by writing a two-byte key, 00h and then FFh, to the refresh register. Any other pattern leaves the count alone. When the counter underflows it reloads and keeps counting, and the block raises either a one-cycle interrupt pulse or a reset request. The reset request is held for `HOLD_CYC` cycles, after which the watchdog puts itself back into its reset state.

A static input chooses between two start modes. In one, the watchdog runs straight after reset. In the other, it waits for any write to the start register. The block captures this input on the first clock edge after reset is released, and software cannot change it afterwards. While the `halt` input is high, the prescaler and the counter both freeze and keep their values.

The main state machine has four states. WD_BOOT captures the start-mode input and then moves to WD_IDLE (wait mode) or to WD_RUN (auto mode). WD_IDLE moves to WD_RUN on a start-register write. WD_RUN moves to WD_HOLD on an underflow when the action bit selects reset. WD_HOLD returns to WD_IDLE or WD_RUN, according to the captured mode, after `HOLD_CYC` cycles.

The key tracker has two states. KEY_CLEAR moves to KEY_ARMED when 00h is written to the refresh register. KEY_ARMED fires a reload and returns to KEY_CLEAR on FFh, stays armed on another 00h, and drops to KEY_CLEAR on any other value.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the count output is all ones, `irq_o` and `rst_req_o` are low, the prescaler divides by 16 and the underflow action is interrupt.
- R2: With `cfg_wait_start`=1 at the first clock after reset, the count holds at all ones until a write to the start register (`wr_addr`=1, any data).
- R3: With `cfg_wait_start`=0 at the first clock after reset, counting begins on the next clock and the first underflow comes 16·2^CNT_W cycles later.
- R4: In divide-by-16 mode the count drops by one every 16 enabled cycles, and the first underflow occurs 16·2^CNT_W enabled cycles after the start write.
- R5: Control register (`wr_addr`=2) bit 0 set to 1 selects divide-by-128, giving a period of 128·2^CNT_W cycles.
- R6: Writing 00h and then FFh to the refresh register (`wr_addr`=0) reloads the count to all ones on the FFh write. Writes to other registers in between do not disturb the key. The prescaler phase is kept across the reload.
- R7: FFh written without a preceding 00h, or a value other than 00h or FFh written after 00h, causes no reload and disarms the key.
- R8: While `halt` is high, the count and the prescaler phase hold. Counting resumes from the held values when `halt` falls.
- R9: With control bit 1 at 0, an underflow reloads the count to all ones, raises `irq_o` for exactly one cycle, and counting continues with the same period.
- R10: With control bit 1 at 1, an underflow raises `rst_req_o` for exactly `HOLD_CYC` cycles. Afterwards the count, prescaler and control bits return to their reset values, and the captured start mode applies again.
- R11: Changing `cfg_wait_start` after the capture edge has no effect, including after a reset request.
- R12: `irq_o` and `rst_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_start | input | 1 | Start mode: 1 waits for a start write, 0 runs automatically |
| halt | input | 1 | Freezes prescaler and counter while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 refresh, 1 start, 2 control, 3 unused |
| wr_data | input | 8 | Write data |
| count_o | output | CNT_W | Current down-counter value |
| irq_o | output | 1 | One-cycle underflow interrupt pulse |
| rst_req_o | output | 1 | Underflow reset request, held HOLD_CYC cycles |

## Verification
The checker watches four properties on every cycle. The count only holds, steps down by one, or jumps to all ones. A frozen input leaves the count unchanged. An adjacent 00h/FFh pair always leaves the count at all ones. The interrupt and reset outputs are exclusive, the interrupt lasts one cycle, and the reset request lasts exactly the hold length.

Only the scoreboard scenarios can show the absolute timing of underflows against the prescaler phase, including the shortened first period after a refresh and the shift caused by a halt. The same applies to the captured start mode, the rejected key patterns, and the return to defaults after a reset request.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_BOOT,
        WD_IDLE,
        WD_RUN,
        WD_HOLD
    } wd_state_e;

    typedef enum logic {
        KEY_CLEAR,
        KEY_ARMED
    } key_state_e;

    localparam logic [1:0] WREG_REFRESH = 2'd0;
    localparam logic [1:0] WREG_START   = 2'd1;
    localparam logic [1:0] WREG_CTRL    = 2'd2;

    localparam logic [7:0] KEY_FIRST  = 8'h00;
    localparam logic [7:0] KEY_SECOND = 8'hFF;

    localparam int CTRL_DIV_BIT = 0;
    localparam int CTRL_ACT_BIT = 1;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_LO = 16,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic sel_hi,
    output logic tick
);
    localparam int PW = $clog2(DIV_HI);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] last_ph;

    always_comb begin
        last_ph = sel_hi ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
    end

    // A divider change in mid-phase is handled by the >= compare.
    always_comb begin
        tick = en && (ph_q >= last_ph);
    end

    // Cleared only by reset or by the block's own reset-hold state, not by refresh.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (clr) begin
            ph_q <= '0;
        end else if (tick) begin
            ph_q <= '0;
        end else if (en) begin
            ph_q <= ph_q + PW'(1);
        end
    end
endmodule

// File: rtl/wdt_refresh_key.sv
module wdt_refresh_key
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       reload
);
    key_state_e key_q;
    key_state_e key_d;

    always_comb begin
        key_d  = key_q;
        reload = 1'b0;
        if (wr_stb) begin
            unique case (key_q)
                KEY_CLEAR: begin
                    key_d = (wr_data == KEY_FIRST) ? KEY_ARMED : KEY_CLEAR;
                end
                KEY_ARMED: begin
                    if (wr_data == KEY_SECOND) begin
                        reload = 1'b1;
                        key_d  = KEY_CLEAR;
                    end else if (wr_data == KEY_FIRST) begin
                        key_d = KEY_ARMED;
                    end else begin
                        key_d = KEY_CLEAR;
                    end
                end
                default: key_d = KEY_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= KEY_CLEAR;
        end else if (clr) begin
            key_q <= KEY_CLEAR;
        end else begin
            key_q <= key_d;
        end
    end
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        underflow = tick && (cnt_q == '0);
        cnt       = cnt_q;
    end

    // A refresh load wins over a tick that lands on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= TOP;
        end else if (clr || load) begin
            cnt_q <= TOP;
        end else if (tick) begin
            cnt_q <= underflow ? TOP : (cnt_q - CNT_W'(1));
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int DIV_LO   = 16,
    parameter int DIV_HI   = 128,
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wait_start,
    input  logic             halt,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    localparam int HW = $clog2(HOLD_CYC) + 1;

    wd_state_e     state_q;
    wd_state_e     state_d;
    logic          cfg_wait_q;
    logic          div_hi_q;
    logic          act_rst_q;
    logic [HW-1:0] hold_q;
    logic          irq_q;

    logic clr;
    logic wr_refresh;
    logic wr_start;
    logic wr_ctrl;
    logic run_en;
    logic tick;
    logic reload;
    logic underflow;

    always_comb begin
        clr        = (state_q == WD_HOLD);
        wr_refresh = wr_en && (wr_addr == WREG_REFRESH) && !clr;
        wr_start   = wr_en && (wr_addr == WREG_START)   && !clr;
        wr_ctrl    = wr_en && (wr_addr == WREG_CTRL)    && !clr;
        run_en     = (state_q == WD_RUN) && !halt;
    end

    wdt_prescaler #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (run_en),
        .sel_hi (div_hi_q),
        .tick   (tick)
    );

    wdt_refresh_key u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_stb  (wr_refresh),
        .wr_data (wr_data),
        .reload  (reload)
    );

    wdt_downcounter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (reload),
        .tick      (tick),
        .cnt       (count_o),
        .underflow (underflow)
    );

    // Control bits: writable outside the hold state, defaults restored by it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_hi_q  <= 1'b0;
            act_rst_q <= 1'b0;
        end else if (clr) begin
            div_hi_q  <= 1'b0;
            act_rst_q <= 1'b0;
        end else if (wr_ctrl) begin
            div_hi_q  <= wr_data[CTRL_DIV_BIT];
            act_rst_q <= wr_data[CTRL_ACT_BIT];
        end
    end

    // Start mode is captured once, on the edge that leaves WD_BOOT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_wait_q <= 1'b1;
        end else if (state_q == WD_BOOT) begin
            cfg_wait_q <= cfg_wait_start;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_BOOT: state_d = cfg_wait_start ? WD_IDLE : WD_RUN;
            WD_IDLE: if (wr_start) state_d = WD_RUN;
            WD_RUN:  if (underflow && act_rst_q) state_d = WD_HOLD;
            WD_HOLD: if (hold_q == HW'(HOLD_CYC - 1)) begin
                         state_d = cfg_wait_q ? WD_IDLE : WD_RUN;
                     end
            default: state_d = WD_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            irq_q  <= (state_q == WD_RUN) && underflow && !act_rst_q;
            hold_q <= (state_q == WD_HOLD) ? (hold_q + HW'(1)) : '0;
        end
    end

    always_comb begin
        irq_o     = irq_q;
        rst_req_o = (state_q == WD_HOLD);
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int HOLD_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_o,
    input logic             rst_req_o
);
    localparam int RW = $clog2(HOLD_CYC + 1) + 1;

    logic [RW-1:0] run_q;
    logic          key_lo;
    logic          key_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= rst_req_o ? (run_q + RW'(1)) : '0;
        end
    end

    always_comb begin
        key_lo = wr_en && (wr_addr == WREG_REFRESH) && (wr_data == KEY_FIRST);
        key_hi = wr_en && (wr_addr == WREG_REFRESH) && (wr_data == KEY_SECOND);
    end

    // R4: the count holds, steps down by one, or is reloaded to all ones
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> (count_o == $past(count_o)) || (count_o == ($past(count_o) - CNT_W'(1)))
                  || (count_o == {CNT_W{1'b1}}));

    // R8: a frozen block does not move its count
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en && !rst_req_o) |=> $stable(count_o));

    // R6: an adjacent 00h/FFh pair leaves the count at all ones
    a_r6_key_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hi && $past(key_lo) && !rst_req_o && !$past(rst_req_o)) |=> (count_o == {CNT_W{1'b1}}));

    // R9: the interrupt lasts one cycle and follows a reload
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r9_irq_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == {CNT_W{1'b1}}));

    // R10: the reset request lasts exactly HOLD_CYC cycles
    a_r10_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (run_q < RW'(HOLD_CYC)));
    a_r10_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> (run_q == RW'(HOLD_CYC)));

    // R12: interrupt and reset request are exclusive
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && rst_req_o));
endmodule

bind keyed_watchdog wdt_checker #(
    .CNT_W    (CNT_W),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_o   (count_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
    import wdt_pkg::*;

    localparam int CW   = 5;
    localparam int DLO  = 16;
    localparam int DHI  = 128;
    localparam int HC   = 4;
    localparam int TOPV = (1 << CW) - 1;
    localparam int NLO  = DLO << CW;
    localparam int NHI  = DHI << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wait = 1'b1;
    logic          halt = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd3;
    logic [7:0]    wr_data = 8'h00;
    logic [CW-1:0] count;
    logic          irq;
    logic          rst_req;

    int cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    int last_edge = 0;
    bit done = 1'b0;
    logic rst_prev = 1'b0;
    int q_cyc[$];
    int q_kind[$];

    keyed_watchdog #(
        .CNT_W    (CW),
        .DIV_LO   (DLO),
        .DIV_HI   (DHI),
        .HOLD_CYC (HC)
    ) u_keyed_watchdog (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wait_start (cfg_wait),
        .halt           (halt),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .count_o        (count),
        .irq_o          (irq),
        .rst_req_o      (rst_req)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver side: one write occupies one clock edge; last_edge is that edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd3;
        last_edge = cyc;
    endtask

    // kind 0 = interrupt pulse, kind 1 = start of reset request
    task automatic expect_evt(input int kind, input int at);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Ticks fall on edges s-1+m*d; the underflow is the 2^CW-th tick after reload edge r.
    function automatic int next_uf(input int s, input int d, input int r);
        int m0;
        m0 = (r - s + 1) / d + 1;
        return s - 1 + m0 * d + TOPV * d;
    endfunction

    task automatic pop_evt(input int kind);
        int c;
        int k;
        if (q_cyc.size() == 0) begin
            vectors++;
            miscompares++;
            $display("FAIL R9/R10 unexpected event: actual kind %0d at %0d expected none", kind, cyc);
        end else begin
            c = q_cyc.pop_front();
            k = q_kind.pop_front();
            chk("R9/R10 event kind", kind, k);
            chk("R4 event cycle", cyc, c);
        end
    endtask

    // Monitor side
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (irq && rst_req) chk("R12 exclusive outputs", 1, 0);
            if (irq) pop_evt(0);
            if (rst_req && !rst_prev) pop_evt(1);
        end
        rst_prev = rst_req;
    end

    task automatic do_reset(input logic wait_mode);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wait = wait_mode;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int s;
        int r;
        int u1;
        int u2;
        int u3;
        int e;
        int hv;
        int c0;

        // R1, R2, R11: reset state and wait mode
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count, TOPV);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        repeat (40) @(negedge clk);
        chk("R2 stopped before start", count, TOPV);
        cfg_wait = 1'b0;
        repeat (40) @(negedge clk);
        chk("R11 mode input ignored after capture", count, TOPV);

        // R4: start and step rate
        wr(WREG_START, 8'h5A);
        s = last_edge + 1;
        wait_cyc(s - 1 + 5 * DLO);
        chk("R4 five ticks", count, TOPV - 5);

        // R8: halt freezes both prescaler and counter
        hv = count;
        halt = 1'b1;
        repeat (37) @(negedge clk);
        chk("R8 count frozen", count, hv);
        halt = 1'b0;
        s = s + 37;

        // R7: bad key patterns
        wr(WREG_REFRESH, 8'hFF);
        chk("R7 lone FF no reload", (count == TOPV) ? 1 : 0, 0);
        wr(WREG_REFRESH, 8'h00);
        wr(WREG_REFRESH, 8'h12);
        wr(WREG_REFRESH, 8'hFF);
        chk("R7 broken key no reload", (count == TOPV) ? 1 : 0, 0);

        // R6: good key with an unrelated write between
        wr(WREG_REFRESH, 8'h00);
        wr(WREG_START, 8'h01);
        wr(WREG_REFRESH, 8'hFF);
        r = last_edge;
        chk("R6 reload", count, TOPV);
        u1 = next_uf(s, DLO, r);
        u2 = u1 + NLO;
        expect_evt(0, u1);
        expect_evt(0, u2);
        wait_cyc(u2 + 2);
        chk("R9 both interrupts seen", q_cyc.size(), 0);

        // R10: reset action
        wr(WREG_CTRL, 8'h02);
        u3 = u2 + NLO;
        expect_evt(1, u3);
        wait_cyc(u3);
        for (int i = 0; i < HC; i++) begin
            chk("R10 request held", rst_req, 1);
            @(negedge clk);
        end
        chk("R10 request released", rst_req, 0);
        repeat (20) @(negedge clk);
        chk("R10 R11 back to waiting with full count", count, TOPV);
        wr(WREG_START, 8'h00);
        e = last_edge;
        expect_evt(0, e + NLO);
        wait_cyc(e + NLO + 2);
        chk("R10 defaults restored", q_cyc.size(), 0);

        // R5: divide-by-128
        do_reset(1'b1);
        wr(WREG_CTRL, 8'h01);
        wr(WREG_START, 8'h00);
        e = last_edge;
        wait_cyc(e + DHI);
        chk("R5 one slow tick", count, TOPV - 1);
        expect_evt(0, e + NHI);
        wait_cyc(e + NHI + 2);
        chk("R5 slow period", q_cyc.size(), 0);

        // R3: auto start
        do_reset(1'b0);
        c0 = cyc;
        wait_cyc(c0 + 1 + DLO);
        chk("R3 counting after reset", count, TOPV - 1);
        expect_evt(0, c0 + 1 + NLO);
        wait_cyc(c0 + NLO + 3);
        chk("R3 auto period", q_cyc.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule